// File: doc/BRIEF.md
# Bypassable Linear Neighbour Network

This block links the processing elements of a SIMD array into a one-dimensional chain for neighbour-to-neighbour shifts. Each element decides for itself whether it takes part. Elements that stay out are skipped, so that two participating elements can exchange data even when many non-participating elements lie between them physically. A global bypass mode can also remove every element that did not respond to the most recent associative search.

On each shift, every element offers one word to both of its neighbours. The word is the element's own register value, the common broadcast word or the common immediate word. The element's receive switch then takes the word from the nearest participating element in the selected direction. The route through the chain is purely combinational. Each element's received word and a valid flag are registered once per shift.

Top module: `lnet_bypass_net`

## Requirements
- R1: After synchronous reset, every element's received word and valid flag are 0.
- R2: With `shift_dir` = 0 (receive from the left), a participating element i captures the offered word of the participating element with the largest index below i, and its valid flag becomes 1.
- R3: With `shift_dir` = 1 (receive from the right), a participating element i captures the offered word of the participating element with the smallest index above i, and its valid flag becomes 1.
- R4: A participating element with no participating element in the selected direction captures word 0 with valid flag 0.
- R5: During a shift, an element that is not participating keeps its received word and valid flag unchanged.
- R6: While `shift_go` is 0, no received word or valid flag changes, whatever the other inputs do.
- R7: Element i participates when `net_en[i]` is 1 and either `prune_mode` is 0 or `responder[i]` is 1. With `prune_mode` = 1, non-responders are therefore dropped from the chain.
- R8: `src_sel` picks the word every element offers: 0 gives the element's own word from `pe_word`, 1 gives `bcast_word`, 2 gives `imm_word`, and 3 behaves as 0.
- R9: A shift takes effect on the clock edge at which `shift_go` is 1. The captured values appear on the outputs right after that edge and stay there until the next shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_go | input | 1 | Perform one shift on this edge |
| shift_dir | input | 1 | 0 = receive from the left, 1 = receive from the right |
| src_sel | input | 2 | Offered word: 0 own, 1 broadcast, 2 immediate, 3 own |
| prune_mode | input | 1 | 1 = drop non-responders from the chain |
| net_en | input | NUM_PE | Per-element in-network enable |
| responder | input | NUM_PE | Per-element result of the last search |
| pe_word | input | NUM_PE*DATA_W | Per-element outgoing words; element i at [i*DATA_W +: DATA_W] |
| bcast_word | input | DATA_W | Common broadcast word |
| imm_word | input | DATA_W | Common immediate word |
| rx_word | output | NUM_PE*DATA_W | Per-element received words, same packing as pe_word |
| rx_valid | output | NUM_PE | Per-element received-word valid flag |

## Verification
The assertions assume that `shift_dir`, `src_sel` and the enable and responder masks are steady across the edge at which a shift is sampled, and that reset is held for at least one edge before the first shift. The bench changes every input only on the falling clock edge and holds `shift_go` high for exactly one rising edge. It also includes idle cycles in which all the other inputs change, so the hold properties are exercised against inputs that are actually moving.

// File: rtl/lnet_pkg.sv
package lnet_pkg;
  typedef enum logic [1:0] {
    SRC_OWN   = 2'd0,
    SRC_BCAST = 2'd1,
    SRC_IMM   = 2'd2,
    SRC_ALT   = 2'd3
  } src_sel_e;

  typedef enum logic {
    DIR_FROM_LEFT  = 1'b0,
    DIR_FROM_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/lnet_src_mux.sv
module lnet_src_mux #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        src_sel,
  input  logic [DATA_W-1:0] own_word,
  input  logic [DATA_W-1:0] bcast_word,
  input  logic [DATA_W-1:0] imm_word,
  output logic [DATA_W-1:0] offer_word
);
  import lnet_pkg::*;

  always_comb begin
    unique case (src_sel_e'(src_sel))
      SRC_BCAST: offer_word = bcast_word;
      SRC_IMM:   offer_word = imm_word;
      default:   offer_word = own_word;
    endcase
  end
endmodule

// File: rtl/lnet_chain.sv
module lnet_chain #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 8,
  localparam int BUS_W = NUM_PE * DATA_W
) (
  input  logic [NUM_PE-1:0] part,
  input  logic [BUS_W-1:0]  offer,
  output logic [BUS_W-1:0]  lft_word,
  output logic [NUM_PE-1:0] lft_vld,
  output logic [BUS_W-1:0]  rgt_word,
  output logic [NUM_PE-1:0] rgt_vld
);
  // Rightward scan: nearest participant at a lower index.
  logic [DATA_W-1:0] l_d [NUM_PE+1];
  logic              l_v [NUM_PE+1];
  // Leftward scan: nearest participant at a higher index.
  logic [DATA_W-1:0] r_d [NUM_PE+1];
  logic              r_v [NUM_PE+1];

  assign l_d[0]      = '0;
  assign l_v[0]      = 1'b0;
  assign r_d[NUM_PE] = '0;
  assign r_v[NUM_PE] = 1'b0;

  for (genvar i = 0; i < NUM_PE; i++) begin : g_hop
    assign l_d[i+1] = part[i] ? offer[i*DATA_W +: DATA_W] : l_d[i];
    assign l_v[i+1] = part[i] | l_v[i];
    assign r_d[i]   = part[i] ? offer[i*DATA_W +: DATA_W] : r_d[i+1];
    assign r_v[i]   = part[i] | r_v[i+1];

    assign lft_word[i*DATA_W +: DATA_W] = l_d[i];
    assign lft_vld[i]                   = l_v[i];
    assign rgt_word[i*DATA_W +: DATA_W] = r_d[i+1];
    assign rgt_vld[i]                   = r_v[i+1];
  end
endmodule

// File: rtl/lnet_rx_switch.sv
module lnet_rx_switch #(
  parameter int DATA_W = 8
) (
  input  logic              shift_dir,
  input  logic [DATA_W-1:0] lft_word,
  input  logic              lft_vld,
  input  logic [DATA_W-1:0] rgt_word,
  input  logic              rgt_vld,
  output logic [DATA_W-1:0] sel_word,
  output logic              sel_vld
);
  import lnet_pkg::*;

  always_comb begin
    if (shift_dir_e'(shift_dir) == DIR_FROM_RIGHT) begin
      sel_word = rgt_word;
      sel_vld  = rgt_vld;
    end else begin
      sel_word = lft_word;
      sel_vld  = lft_vld;
    end
  end
endmodule

// File: rtl/lnet_bypass_net.sv
module lnet_bypass_net #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 8,
  localparam int BUS_W = NUM_PE * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_go,
  input  logic              shift_dir,
  input  logic [1:0]        src_sel,
  input  logic              prune_mode,
  input  logic [NUM_PE-1:0] net_en,
  input  logic [NUM_PE-1:0] responder,
  input  logic [BUS_W-1:0]  pe_word,
  input  logic [DATA_W-1:0] bcast_word,
  input  logic [DATA_W-1:0] imm_word,
  output logic [BUS_W-1:0]  rx_word,
  output logic [NUM_PE-1:0] rx_valid
);
  logic [NUM_PE-1:0] part;
  logic [BUS_W-1:0]  offer;
  logic [BUS_W-1:0]  lft_word, rgt_word, nxt_word;
  logic [NUM_PE-1:0] lft_vld, rgt_vld, nxt_vld;

  assign part = net_en & (responder | {NUM_PE{~prune_mode}});

  lnet_chain #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_chain (
    .part     (part),
    .offer    (offer),
    .lft_word (lft_word),
    .lft_vld  (lft_vld),
    .rgt_word (rgt_word),
    .rgt_vld  (rgt_vld)
  );

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    lnet_src_mux #(.DATA_W(DATA_W)) u_src (
      .src_sel    (src_sel),
      .own_word   (pe_word[i*DATA_W +: DATA_W]),
      .bcast_word (bcast_word),
      .imm_word   (imm_word),
      .offer_word (offer[i*DATA_W +: DATA_W])
    );

    lnet_rx_switch #(.DATA_W(DATA_W)) u_sw (
      .shift_dir (shift_dir),
      .lft_word  (lft_word[i*DATA_W +: DATA_W]),
      .lft_vld   (lft_vld[i]),
      .rgt_word  (rgt_word[i*DATA_W +: DATA_W]),
      .rgt_vld   (rgt_vld[i]),
      .sel_word  (nxt_word[i*DATA_W +: DATA_W]),
      .sel_vld   (nxt_vld[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rx_word[i*DATA_W +: DATA_W] <= '0;
        rx_valid[i]                 <= 1'b0;
      end else if (shift_go && part[i]) begin
        rx_word[i*DATA_W +: DATA_W] <= nxt_vld[i] ? nxt_word[i*DATA_W +: DATA_W] : '0;
        rx_valid[i]                 <= nxt_vld[i];
      end
    end

    AST_BYPASSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (shift_go && !part[i]) |=> ($stable(rx_word[i*DATA_W +: DATA_W]) && $stable(rx_valid[i]))); // R5

    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
      !rx_valid[i] |-> (rx_word[i*DATA_W +: DATA_W] == '0)); // R4

    if (i > 0) begin : g_left_pair
      AST_LEFT_NEIGHBOUR: assert property (@(posedge clk) disable iff (rst)
        (shift_go && !shift_dir && part[i] && part[i-1]) |=>
        (rx_valid[i] && rx_word[i*DATA_W +: DATA_W] == $past(offer[(i-1)*DATA_W +: DATA_W]))); // R2
    end
    if (i < NUM_PE-1) begin : g_right_pair
      AST_RIGHT_NEIGHBOUR: assert property (@(posedge clk) disable iff (rst)
        (shift_go && shift_dir && part[i] && part[i+1]) |=>
        (rx_valid[i] && rx_word[i*DATA_W +: DATA_W] == $past(offer[(i+1)*DATA_W +: DATA_W]))); // R3
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !shift_go |=> ($stable(rx_word) && $stable(rx_valid))); // R6

  AST_LEFT_EDGE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (shift_go && !shift_dir && part[0]) |=> !rx_valid[0]); // R4

  AST_RIGHT_EDGE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (shift_go && shift_dir && part[NUM_PE-1]) |=> !rx_valid[NUM_PE-1]); // R4
endmodule

// File: tb/lnet_bypass_net_tb.sv
module lnet_bypass_net_tb;
  localparam int N  = 8;
  localparam int DW = 8;

  typedef struct {
    logic [N*DW-1:0] d;
    logic [N-1:0]    v;
    int              due;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst;
  logic shift_go, shift_dir, prune_mode;
  logic [1:0] src_sel;
  logic [N-1:0] net_en, responder;
  logic [N*DW-1:0] pe_word;
  logic [DW-1:0] bcast_word, imm_word;
  logic [N*DW-1:0] rx_word;
  logic [N-1:0] rx_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [N*DW-1:0] m_d;
  logic [N-1:0]    m_v;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lnet_bypass_net #(.NUM_PE(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .shift_go(shift_go), .shift_dir(shift_dir),
    .src_sel(src_sel), .prune_mode(prune_mode), .net_en(net_en),
    .responder(responder), .pe_word(pe_word), .bcast_word(bcast_word),
    .imm_word(imm_word), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  // Monitor: compares the head of the scoreboard on its due falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rx_word !== e.d || rx_valid !== e.v) begin
        errors++;
        $display("FAIL %s: actual word=%h valid=%b expected word=%h valid=%b",
                 e.tag, rx_word, rx_valid, e.d, e.v);
      end
    end
  end

  function automatic logic [DW-1:0] offer_of(int j, logic [1:0] s);
    case (s)
      2'd1:    return bcast_word;
      2'd2:    return imm_word;
      default: return pe_word[j*DW +: DW];
    endcase
  endfunction

  task automatic push_model(string tag);
    exp_t e;
    e.d = m_d; e.v = m_v; e.due = cyc + 1; e.tag = tag;
    sb.push_back(e);
  endtask

  // Driver: applies one shift at a falling edge and pushes the expected result.
  task automatic do_shift(logic dir, logic [1:0] s, logic pm, logic [N-1:0] en,
                          logic [N-1:0] rs, logic [7:0] seed, string tag);
    logic [N-1:0] p;
    shift_dir = dir; src_sel = s; prune_mode = pm; net_en = en; responder = rs;
    for (int k = 0; k < N; k++) pe_word[k*DW +: DW] = DW'(seed + 8'(k * 17));
    bcast_word = seed ^ 8'hA5;
    imm_word   = seed ^ 8'h3C;
    shift_go   = 1'b1;
    p = en & (rs | {N{~pm}});
    for (int i = 0; i < N; i++) begin
      if (p[i]) begin
        int src = -1;
        if (!dir) begin
          for (int j = 0; j < i; j++) if (p[j]) src = j;
        end else begin
          for (int j = N-1; j > i; j--) if (p[j]) src = j;
        end
        m_v[i] = (src >= 0);
        m_d[i*DW +: DW] = (src >= 0) ? offer_of(src, s) : '0;
      end
    end
    push_model(tag);
    @(negedge clk);
    shift_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_cycle(string tag);
    shift_go = 1'b0; shift_dir = ~shift_dir; src_sel = src_sel + 2'd1;
    net_en = ~net_en; responder = ~responder; pe_word = ~pe_word;
    bcast_word = ~bcast_word; imm_word = ~imm_word;
    push_model(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9: watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; shift_go = 1'b0; shift_dir = 1'b0; src_sel = 2'd0; prune_mode = 1'b0;
    net_en = '1; responder = '0; pe_word = '0; bcast_word = '0; imm_word = '0;
    m_d = '0; m_v = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    push_model("R1 reset state");
    @(negedge clk); @(negedge clk);

    do_shift(1'b0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h10, "R2 R4 R9 all in, from left");
    do_shift(1'b1, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h21, "R3 R4 R9 all in, from right");
    do_shift(1'b0, 2'd0, 1'b0, 8'hA5, 8'h00, 8'h32, "R2 R5 sparse chain, from left");
    do_shift(1'b1, 2'd0, 1'b0, 8'hA5, 8'h00, 8'h43, "R3 R5 sparse chain, from right");
    do_shift(1'b0, 2'd0, 1'b1, 8'hFF, 8'h49, 8'h54, "R7 prune drops non-responders");
    do_shift(1'b1, 2'd0, 1'b0, 8'hFF, 8'h49, 8'h65, "R7 no prune, all enabled join");
    do_shift(1'b1, 2'd0, 1'b1, 8'h0F, 8'hF9, 8'h76, "R7 prune with partial enable");
    do_shift(1'b0, 2'd1, 1'b0, 8'h66, 8'h00, 8'h87, "R8 broadcast source");
    do_shift(1'b1, 2'd2, 1'b0, 8'h99, 8'h00, 8'h98, "R8 immediate source");
    do_shift(1'b0, 2'd3, 1'b0, 8'hFF, 8'h00, 8'hA9, "R8 code 3 offers own word");
    idle_cycle("R6 no shift, inputs moving");
    do_shift(1'b0, 2'd0, 1'b0, 8'h08, 8'h00, 8'hBA, "R4 lone participant");
    do_shift(1'b1, 2'd0, 1'b1, 8'hFF, 8'h00, 8'hCB, "R5 nobody participates");
    do_shift(1'b1, 2'd0, 1'b0, 8'h81, 8'h00, 8'hDC, "R2 R3 far-apart pair, from right");
    do_shift(1'b0, 2'd0, 1'b0, 8'h81, 8'h00, 8'hED, "R2 far-apart pair, from left");
    idle_cycle("R6 second idle");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: actual pending=%0d expected pending=0", sb.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule